// File: doc/BRIEF.md
# Packed-Word Palette Loader

This block is a colour lookup table of 256 entries, each holding an 8-bit red, green and blue value. A host fills it through a synchronous register port with three targets, chosen by a 2-bit select: an address register, a colour data port and a control port. Colour data comes in 32-bit words, and each word carries four bytes of one continuous stream of components. Three words therefore fill four entries, and a component boundary can fall in the middle of a word. The block keeps an internal byte pointer into that stream. The pointer advances on its own, so the host can stream words without break to load the table group by group.

The address register has two jobs. It selects the group to load, and it selects which internal control register a control-port write goes to. One such register is a read mask, which is ANDed with every pixel index before the lookup. The pixel side takes an 8-bit index and returns the 24-bit colour one clock later.

Top module: `palette_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pix_rgb` becomes 0 and the read mask becomes 0xFF, so after reset every index looks up its own entry.
- R2: A write with `wr_sel`=0 (address) and a value below 256 points the loader at the red component of the entry given by that value with its low two bits cleared. For example, 0x0B starts loading at entry 8.
- R3: Words written with `wr_sel`=1 (colour data) are split into bytes with the most significant byte first. These bytes fill components in the order red, green, blue, one entry after another. Words 0x11223344, 0x55667788 and 0x99AABBCC loaded from entry 0 give entries 0 to 3 the values 0x112233, 0x445566, 0x778899 and 0xAABBCC, with red in `pix_rgb[23:16]`.
- R4: After the third word of a group, the next word goes on to the group that follows, and the stream wraps from entry 255 back to entry 0.
- R5: An address write made part way through a group resets the byte pointer to the red component of the group it names.
- R6: An address write whose value is 256 or more (any of `wr_data[31:8]` set) is ignored. The byte pointer and the control register selection both keep their previous values.
- R7: `pix_rgb` holds the entry for the index presented one clock earlier. If a colour word is written in the same cycle as the lookup of the entry it changes, that lookup returns the old colour, and the next one returns the new colour.
- R8: A write with `wr_sel`=2 (control) stores `wr_data[7:0]` into the control register chosen by the last valid address write. Register 4 is the read mask, ANDed with `pix_idx` before the lookup.
- R9: Control writes to any register other than 4 do not change lookups. No control write moves the byte pointer.
- R10: A write with `wr_sel`=3 changes neither the palette, nor the byte pointer, nor the read mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 address, 1 colour data, 2 control, 3 none |
| wr_data | input | 32 | Write value |
| pix_idx | input | 8 | Pixel index to look up |
| pix_rgb | output | 24 | Colour for the previous cycle's index, {red, green, blue} |

## Verification
Two functions can meet in one cycle: a colour word lands in the table while the lookup port reads the entry that word completes. The bench forces this by driving the third word of a group and that group's last index on the same clock edge. It expects the old colour after that edge and the new colour one edge later. The same timing rule is applied to read-mask writes against lookups, and to stray control and unused-select writes placed between the words of a group, which must leave the byte stream intact.

// File: rtl/palette_pkg.sv
// Package: shared encoding of the host write-port select.
// Assumes: the select is a 2-bit field driven together with the write strobe.
package palette_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_CMAP = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_e;
endpackage

// File: rtl/palette_ptr.sv
// Module: palette_ptr
// Keeps the address register and the byte-stream pointer into the flat
// component array (entry*3 + component).
// Assumes: one word of BPW bytes per colour write; address values of NENT
// or more are rejected.
module palette_ptr #(
    parameter int NENT = 256,
    parameter int CW   = 8,
    parameter int WW   = 32,
    localparam int NBYTES = NENT * 3,
    localparam int PW     = $clog2(NBYTES),
    localparam int IW     = $clog2(NENT),
    localparam int BPW    = WW / CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic          cmap_we,
    input  logic [WW-1:0] wr_data,
    output logic [PW-1:0] byte_ptr,
    output logic [IW-1:0] reg_sel
);
    logic          addr_ok;
    logic [IW-1:0] entry_al;
    logic [PW-1:0] grp_start;
    logic [PW:0]   ptr_sum;
    logic [PW-1:0] ptr_nxt;

    // Decode validity and the first byte of the selected group.
    always_comb begin
        addr_ok   = (wr_data[WW-1:IW] == '0);
        entry_al  = wr_data[IW-1:0] & ~IW'(BPW - 1);
        grp_start = PW'(entry_al) * PW'(3);
    end

    // Next stream position after one word, wrapping at the table end.
    always_comb begin
        ptr_sum = {1'b0, byte_ptr} + (PW+1)'(BPW);
        ptr_nxt = (ptr_sum >= (PW+1)'(NBYTES)) ? '0 : ptr_sum[PW-1:0];
    end

    // Update selection and pointer on address or colour writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_ptr <= '0;
            reg_sel  <= '0;
        end else if (addr_we && addr_ok) begin
            byte_ptr <= grp_start;
            reg_sel  <= wr_data[IW-1:0];
        end else if (cmap_we) begin
            byte_ptr <= ptr_nxt;
        end
    end
endmodule

// File: rtl/palette_mask_reg.sv
// Module: palette_mask_reg
// Holds the read-mask control register; control writes aimed at any other
// index are accepted and have no effect.
// Assumes: the register index comes from the address register.
module palette_mask_reg #(
    parameter int CW       = 8,
    parameter int IW       = 8,
    parameter int MASK_IDX = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [IW-1:0] reg_sel,
    input  logic [CW-1:0] din,
    output logic [CW-1:0] read_mask
);
    // Load the mask when its index is selected; reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read_mask <= '1;
        end else if (ctrl_we && (reg_sel == IW'(MASK_IDX))) begin
            read_mask <= din;
        end
    end
endmodule

// File: rtl/palette_store.sv
// Module: palette_store
// Flat byte array of NENT*3 components, written BPW bytes per word with the
// most significant byte first, and read by a registered lookup.
// Assumes: the write pointer is always a multiple of BPW, so a word never
// crosses the end of the array.
module palette_store #(
    parameter int NENT = 256,
    parameter int CW   = 8,
    parameter int WW   = 32,
    localparam int NBYTES = NENT * 3,
    localparam int PW     = $clog2(NBYTES),
    localparam int IW     = $clog2(NENT),
    localparam int BPW    = WW / CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [PW-1:0]   ptr,
    input  logic [WW-1:0]   wdata,
    input  logic [IW-1:0]   idx,
    output logic [3*CW-1:0] rgb
);
    logic [CW-1:0] mem [NBYTES];
    logic [PW-1:0] base;

    // Write all bytes of one colour word into consecutive components.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < BPW; b++) begin
                mem[ptr + PW'(b)] <= wdata[WW-1-b*CW -: CW];
            end
        end
    end

    // First component of the looked-up entry.
    always_comb base = PW'(idx) * PW'(3);

    // Registered read of the three components of one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb <= '0;
        end else begin
            rgb <= {mem[base], mem[base + PW'(1)], mem[base + PW'(2)]};
        end
    end
endmodule

// File: rtl/palette_loader.sv
// Module: palette_loader (top)
// Palette with packed-word loading, indirect control registers and a
// masked, registered pixel lookup.
// Assumes: a simple synchronous write strobe; video timing handled elsewhere.
module palette_loader #(
    parameter int NENT     = 256,
    parameter int CW       = 8,
    parameter int WW       = 32,
    parameter int MASK_IDX = 4,
    localparam int NBYTES  = NENT * 3,
    localparam int PW      = $clog2(NBYTES),
    localparam int IW      = $clog2(NENT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [WW-1:0]   wr_data,
    input  logic [IW-1:0]   pix_idx,
    output logic [3*CW-1:0] pix_rgb
);
    import palette_pkg::*;

    port_sel_e     sel;
    logic          addr_we;
    logic          cmap_we;
    logic          ctrl_we;
    logic [PW-1:0] byte_ptr;
    logic [IW-1:0] reg_sel;
    logic [CW-1:0] read_mask;
    logic [IW-1:0] idx_masked;

    // Decode the write strobe into one target.
    always_comb begin
        sel     = port_sel_e'(wr_sel);
        addr_we = wr_en && (sel == SEL_ADDR);
        cmap_we = wr_en && (sel == SEL_CMAP);
        ctrl_we = wr_en && (sel == SEL_CTRL);
    end

    // Apply the read mask to the pixel index.
    always_comb idx_masked = pix_idx & IW'(read_mask);

    palette_ptr #(.NENT(NENT), .CW(CW), .WW(WW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_we  (addr_we),
        .cmap_we  (cmap_we),
        .wr_data  (wr_data),
        .byte_ptr (byte_ptr),
        .reg_sel  (reg_sel)
    );

    palette_mask_reg #(.CW(CW), .IW(IW), .MASK_IDX(MASK_IDX)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .reg_sel   (reg_sel),
        .din       (wr_data[CW-1:0]),
        .read_mask (read_mask)
    );

    palette_store #(.NENT(NENT), .CW(CW), .WW(WW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cmap_we),
        .ptr   (byte_ptr),
        .wdata (wr_data),
        .idx   (idx_masked),
        .rgb   (pix_rgb)
    );
endmodule

// File: rtl/palette_loader_chk.sv
// Module: palette_loader_chk
// Temporal checks on the pointer, selection and mask of palette_loader.
// Assumes: bound to every palette_loader instance by the bind below.
module palette_loader_chk #(
    parameter int NENT     = 256,
    parameter int CW       = 8,
    parameter int WW       = 32,
    parameter int MASK_IDX = 4,
    localparam int NBYTES  = NENT * 3,
    localparam int PW      = $clog2(NBYTES),
    localparam int IW      = $clog2(NENT),
    localparam int BPW     = WW / CW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_sel,
    input logic [WW-1:0] wr_data,
    input logic [PW-1:0] byte_ptr,
    input logic [IW-1:0] reg_sel,
    input logic [CW-1:0] read_mask
);
    AST_GROUP_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && wr_data[WW-1:IW] == '0)
        |=> (int'(byte_ptr) % (3*BPW) == 0));  // R2

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1)
        |=> (int'(byte_ptr) == (int'($past(byte_ptr)) + BPW) % NBYTES));  // R4

    AST_PTR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(byte_ptr) % BPW == 0));  // R3

    AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && wr_data[WW-1:IW] != '0)
        |=> ($stable(byte_ptr) && $stable(reg_sel)));  // R6

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'd2 && reg_sel == IW'(MASK_IDX))
        |=> $stable(read_mask));  // R9

    AST_CTRL_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> $stable(byte_ptr));  // R9

    AST_NOP_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3)
        |=> ($stable(byte_ptr) && $stable(read_mask)));  // R10
endmodule

bind palette_loader palette_loader_chk #(
    .NENT(NENT), .CW(CW), .WW(WW), .MASK_IDX(MASK_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .byte_ptr  (byte_ptr),
    .reg_sel   (reg_sel),
    .read_mask (read_mask)
);

// File: tb/palette_loader_tb.sv
module palette_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [7:0]  pix_idx;
    logic [23:0] pix_rgb;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] sh [768];
    int bp = 0;
    logic [7:0] mask = 8'hFF;

    always #2 clk = ~clk;

    palette_loader u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic m_addr(input logic [31:0] v);
        wr(2'd0, v);
        if (v < 256) bp = int'(v & ~32'd3) * 3;
    endtask

    task automatic m_word(input logic [31:0] w);
        wr(2'd1, w);
        for (int b = 0; b < 4; b++) sh[bp + b] = w[31-8*b -: 8];
        bp = (bp + 4) % 768;
    endtask

    function automatic logic [23:0] exp_rgb(input int e);
        return {sh[3*e], sh[3*e+1], sh[3*e+2]};
    endfunction

    function automatic logic [31:0] fw(input int k);
        return (32'(k) * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction

    task automatic look(input string tag, input int idx);
        @(negedge clk);
        pix_idx = 8'(idx);
        @(negedge clk);
        check(tag, pix_rgb, exp_rgb(int'(8'(idx) & mask)));
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [23:0] old_c;
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; pix_idx = '0;
        repeat (3) @(negedge clk);
        check("R1 reset output", pix_rgb, 24'h0);
        rst_n = 1'b1;

        // R3: explicit big-endian stream into entries 0..3
        m_addr(32'd0);
        m_word(32'h11223344); m_word(32'h55667788); m_word(32'h99AABBCC);
        @(negedge clk); pix_idx = 8'd0; @(negedge clk); check("R3 entry0", pix_rgb, 24'h112233);
        pix_idx = 8'd1; @(negedge clk); check("R3 entry1", pix_rgb, 24'h445566);
        pix_idx = 8'd2; @(negedge clk); check("R3 entry2", pix_rgb, 24'h778899);
        pix_idx = 8'd3; @(negedge clk); check("R3 entry3", pix_rgb, 24'hAABBCC);

        // R3/R4: fill the whole table with one continuous stream
        m_addr(32'd0);
        for (int k = 0; k < 192; k++) m_word(fw(k));
        for (int i = 0; i < 256; i++) look("R3 sweep", i);
        look("R1 reset mask", 255);

        // R4: wrap from the last group to entry 0
        m_addr(32'd252);
        for (int k = 0; k < 6; k++) m_word(fw(k + 500));
        for (int i = 252; i < 256; i++) look("R4 wrap tail", i);
        for (int i = 0; i < 4; i++) look("R4 wrap head", i);

        // R2: low two address bits ignored
        m_addr(32'h0B);
        for (int k = 0; k < 3; k++) m_word(fw(k + 600));
        for (int i = 8; i < 12; i++) look("R2 group start", i);
        look("R2 next group intact", 12);

        // R5: restart mid-group
        m_addr(32'd16);
        m_word(fw(700));
        m_addr(32'd16);
        for (int k = 0; k < 3; k++) m_word(fw(k + 710));
        for (int i = 16; i < 21; i++) look("R5 restart", i);

        // R6: invalid address ignored mid-group
        m_addr(32'd32);
        m_word(fw(800));
        m_addr(32'h0000_0128);
        m_word(fw(801)); m_word(fw(802));
        for (int i = 32; i < 36; i++) look("R6 pointer kept", i);
        look("R6 entry40 untouched", 40);

        // R8: read mask applied to lookups
        m_addr(32'd4);
        wr(2'd2, 32'h0F); mask = 8'h0F;
        for (int i = 0; i < 256; i += 17) look("R8 mask 0F", i);
        look("R8 mask 0F high index", 8'hF3);

        // R6: invalid address keeps register selection
        m_addr(32'h0000_0107);
        wr(2'd2, 32'h3F); mask = 8'h3F;
        look("R6 selection kept", 8'hFF);
        look("R8 mask 3F", 8'hC5);

        // R9: other control registers have no effect
        m_addr(32'd5); wr(2'd2, 32'h00);
        m_addr(32'd6); wr(2'd2, 32'h70);
        m_addr(32'd7); wr(2'd2, 32'h00);
        look("R9 mask unchanged", 8'hF3);
        m_addr(32'd4); wr(2'd2, 32'hFF); mask = 8'hFF;
        look("R8 mask restored", 8'hF3);

        // R9: control write between words leaves the stream intact
        m_addr(32'd60);
        m_word(fw(900));
        wr(2'd2, 32'h55);
        m_word(fw(901)); m_word(fw(902));
        for (int i = 60; i < 64; i++) look("R9 stream intact", i);
        look("R9 mask after stray ctrl", 8'hF0);

        // R10: unused select changes nothing
        m_addr(32'd64);
        m_word(fw(1000));
        wr(2'd3, 32'h0000_0000);
        m_word(fw(1001)); m_word(fw(1002));
        for (int i = 64; i < 68; i++) look("R10 stream intact", i);
        look("R10 mask intact", 8'hF0);

        // R7: write and lookup of the same entry in one cycle
        m_addr(32'd48);
        m_word(fw(1100)); m_word(fw(1101));
        old_c = exp_rgb(51);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = fw(1102); pix_idx = 8'd51;
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 same-cycle old value", pix_rgb, old_c);
        for (int b = 0; b < 4; b++) sh[bp + b] = fw(1102)[31-8*b -: 8];
        bp = (bp + 4) % 768;
        @(negedge clk);
        check("R7 next-cycle new value", pix_rgb, exp_rgb(51));
        look("R7 latency entry 50", 50);

        summary();
    end
endmodule